// File: doc/BRIEF.md
# Receive Address Filter

This block decides whether an incoming Ethernet frame should be kept, based on its 48-bit destination address. It compares the destination with the station's own address and with the all-ones broadcast address. It also looks the destination up in a 64-entry hash table, where the index comes from a CRC-32 over the six destination bytes. Five enables select which kinds of frame are kept. The outcome is an accept flag and a 16-bit receive-event status word.

A frame is launched with a one-cycle `start` pulse, which carries the destination, the frame length and a CRC-error flag. The hash runs one byte per clock. The result appears as a one-cycle `done` pulse, and the accept flag and status word hold their values until the next result. The hash table is loaded one byte at a time through a small write port. Storing frames and sequencing their readout are left to the surrounding logic.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset `done`, `accept` and `status` are 0. The `start` pulse is sampled on a rising edge. `done` is a one-cycle pulse registered on the 7th rising edge after that edge. `accept` and `status` change only in that same cycle and then hold.
- R2: A `start` that arrives while a decision is in progress is ignored. It produces no extra `done` and does not change the pending result.
- R3: If the destination equals `station_addr`, the frame is accepted when `en_ia` or `en_prom` is set. Otherwise the frame goes on to the broadcast, hash and promiscuous checks below.
- R4: An all-ones destination is accepted only when `en_bcast` or `en_prom` is set. It never consults the hash table.
- R5: The hash register starts at 0xFFFFFFFF. Each step shifts right by one and XORs 0xEDB88320 whenever the bit shifted out differs from the data bit. Data is fed least-significant bit first, byte `dst_addr[7:0]` first. No final inversion is applied. The hash index is bits [31:26] of the result and selects bit `index` of the 64-bit mask.
- R6: If the selected mask bit is set and `dst_addr[7]` is 1, the frame is a multicast. It is accepted when `en_mcast` or `en_prom` is set. An accepted multicast carries 0x0200 and uses the address-type format.
- R7: If the selected mask bit is set and `dst_addr[7]` is 0, the frame is accepted when `en_hash` or `en_prom` is set. Its status is 0x0004 | 0x0100 | 0x0040 | (index << 9).
- R8: A frame that reaches none of the cases above is accepted only when `en_prom` is set.
- R9: An accepted frame that is not a hashed unicast has the status 0x0104, plus the following bits:
  - 0x0400 when the destination matched `station_addr`;
  - 0x0800 when it was taken as broadcast;
  - 0x1000 when `crc_err` was set;
  - 0x2000 when the length is below 64;
  - 0x4000 when the length is above 1518.
- R10: A rejected frame gives `accept` = 0 and `status` = 0x0004.
- R11: A cycle with `mask_wr` high writes `mask_byte` into mask bits [8n+7:8n], where n = `mask_sel`. The other mask bytes are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch a decision for the frame on the inputs below |
| dst_addr | input | 48 | Destination address; bits [7:0] are the first byte on the wire |
| frame_len | input | 16 | Frame length in bytes |
| crc_err | input | 1 | Frame check sequence error flag |
| station_addr | input | 48 | Station address, same byte order as `dst_addr` |
| en_ia | input | 1 | Accept frames addressed to the station |
| en_bcast | input | 1 | Accept broadcast frames |
| en_mcast | input | 1 | Accept multicast frames that hit the hash table |
| en_hash | input | 1 | Accept unicast frames that hit the hash table |
| en_prom | input | 1 | Accept every frame |
| mask_wr | input | 1 | Hash-mask byte write strobe |
| mask_sel | input | 3 | Hash-mask byte number |
| mask_byte | input | 8 | Hash-mask byte data |
| done | output | 1 | One-cycle pulse: a new result is valid |
| accept | output | 1 | Frame is kept |
| status | output | 16 | Receive-event status word |

## Verification
The frame inputs and enables are captured on the `start` edge. One byte is hashed on each of the next six edges, and the result is registered on the seventh. `done`, `accept` and `status` therefore all change together, seven edges after the sampling edge. Mask writes take effect on the edge that samples `mask_wr`. The reference model records the due cycle when it launches a frame. On every clock it samples 3 ns after the rising edge and expects `done` in exactly that cycle and nowhere else. It also expects `accept` and `status` to hold their last result between pulses. This catches early or late results, stray pulses and starts that are wrongly honoured while the block is busy.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;

    localparam logic [31:0] CRC_POLY = 32'hEDB88320;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HASH   = 2'd1,
        ST_DECIDE = 2'd2
    } rxaf_state_e;

    typedef struct packed {
        logic ia;
        logic bcast;
        logic mcast;
        logic hash;
        logic prom;
    } rxaf_en_t;

    localparam logic [15:0] SW_BASE   = 16'h0004;
    localparam logic [15:0] SW_RXOK   = 16'h0100;
    localparam logic [15:0] SW_MCAST  = 16'h0200;
    localparam logic [15:0] SW_HASHED = 16'h0040;
    localparam logic [15:0] SW_IA     = 16'h0400;
    localparam logic [15:0] SW_BCAST  = 16'h0800;
    localparam logic [15:0] SW_CRCERR = 16'h1000;
    localparam logic [15:0] SW_RUNT   = 16'h2000;
    localparam logic [15:0] SW_LONG   = 16'h4000;

endpackage

// File: rtl/rxaf_crc_step.sv
module rxaf_crc_step #(
    parameter logic [31:0] POLY = rxaf_pkg::CRC_POLY
) (
    input  logic [31:0] crc_in,
    input  logic [7:0]  data_in,
    output logic [31:0] crc_out
);
    logic [31:0] c;

    always_comb begin
        c = crc_in;
        for (int i = 0; i < 8; i++) begin
            if (c[0] ^ data_in[i]) c = (c >> 1) ^ POLY;
            else                   c = c >> 1;
        end
        crc_out = c;
    end
endmodule

// File: rtl/rxaf_hash_mask.sv
module rxaf_hash_mask #(
    parameter  int MASK_BYTES = 8,
    localparam int SEL_W      = $clog2(MASK_BYTES),
    localparam int MASK_BITS  = MASK_BYTES * 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [SEL_W-1:0]     wr_sel,
    input  logic [7:0]           wr_byte,
    output logic [MASK_BITS-1:0] mask
);
    logic [MASK_BITS-1:0] mask_d, mask_q;

    for (genvar g = 0; g < MASK_BYTES; g++) begin : g_lane
        assign mask_d[g*8 +: 8] = (wr_en && wr_sel == SEL_W'(g)) ? wr_byte : mask_q[g*8 +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    assign mask = mask_q;
endmodule

// File: rtl/rxaf_decide.sv
module rxaf_decide
    import rxaf_pkg::*;
#(
    parameter  int ADDR_BYTES = 6,
    parameter  int MASK_BITS  = 64,
    parameter  int LEN_W      = 16,
    parameter  int MIN_LEN    = 64,
    parameter  int MAX_LEN    = 1518,
    localparam int AW         = ADDR_BYTES * 8,
    localparam int IDX_W      = $clog2(MASK_BITS)
) (
    input  logic [AW-1:0]        dst,
    input  logic [AW-1:0]        station,
    input  logic [31:0]          crc,
    input  logic [MASK_BITS-1:0] mask,
    input  rxaf_en_t             en,
    input  logic                 crc_err,
    input  logic [LEN_W-1:0]     len,
    output logic                 accept,
    output logic [15:0]          status
);
    logic [IDX_W-1:0] idx;
    logic ia_m, bc_m, hit, f_bc, f_mc, f_h;

    assign idx  = crc[31 -: IDX_W];
    assign hit  = mask[idx];
    assign ia_m = (dst == station);
    assign bc_m = &dst;

    always_comb begin
        accept = 1'b0;
        f_bc   = 1'b0;
        f_mc   = 1'b0;
        f_h    = 1'b0;
        if (ia_m && (en.ia || en.prom)) begin
            accept = 1'b1;
        end else if (bc_m) begin
            f_bc   = 1'b1;
            accept = en.bcast || en.prom;
        end else if (hit) begin
            if (dst[7]) begin
                f_mc   = 1'b1;
                accept = en.mcast || en.prom;
            end else begin
                f_h    = 1'b1;
                accept = en.hash || en.prom;
            end
        end else begin
            accept = en.prom;
        end

        status = SW_BASE;
        if (accept) begin
            status = status | SW_RXOK;
            if (f_mc) status = status | SW_MCAST;
            if (f_h) begin
                status = status | SW_HASHED | (16'(idx) << 9);
            end else begin
                if (ia_m)                       status = status | SW_IA;
                if (f_bc)                       status = status | SW_BCAST;
                if (crc_err)                    status = status | SW_CRCERR;
                if (len < LEN_W'(MIN_LEN))      status = status | SW_RUNT;
                if (len > LEN_W'(MAX_LEN))      status = status | SW_LONG;
            end
        end
    end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rxaf_pkg::*;
#(
    parameter  int ADDR_BYTES = 6,
    parameter  int MASK_BYTES = 8,
    parameter  int LEN_W      = 16,
    parameter  int MIN_LEN    = 64,
    parameter  int MAX_LEN    = 1518,
    localparam int AW         = ADDR_BYTES * 8,
    localparam int SEL_W      = $clog2(MASK_BYTES),
    localparam int MASK_BITS  = MASK_BYTES * 8,
    localparam int CNT_W      = $clog2(ADDR_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [AW-1:0]    dst_addr,
    input  logic [LEN_W-1:0] frame_len,
    input  logic             crc_err,
    input  logic [AW-1:0]    station_addr,
    input  logic             en_ia,
    input  logic             en_bcast,
    input  logic             en_mcast,
    input  logic             en_hash,
    input  logic             en_prom,
    input  logic             mask_wr,
    input  logic [SEL_W-1:0] mask_sel,
    input  logic [7:0]       mask_byte,
    output logic             done,
    output logic             accept,
    output logic [15:0]      status
);
    typedef struct packed {
        rxaf_state_e      st;
        logic [CNT_W-1:0] cnt;
        logic [AW-1:0]    dst;
        logic [AW-1:0]    station;
        logic [LEN_W-1:0] len;
        logic             crc_err;
        rxaf_en_t         en;
        logic [31:0]      crc;
        logic             done;
        logic             accept;
        logic [15:0]      status;
    } ctl_t;

    ctl_t                 ctl_d, ctl_q;
    logic [MASK_BITS-1:0] hash_mask;
    logic [31:0]          crc_next;
    logic [7:0]           cur_byte;
    logic                 dec_accept;
    logic [15:0]          dec_status;

    rxaf_hash_mask #(.MASK_BYTES(MASK_BYTES)) u_mask (
        .clk(clk), .rst_n(rst_n), .wr_en(mask_wr), .wr_sel(mask_sel),
        .wr_byte(mask_byte), .mask(hash_mask)
    );

    assign cur_byte = ctl_q.dst[{ctl_q.cnt, 3'b000} +: 8];

    rxaf_crc_step u_crc (.crc_in(ctl_q.crc), .data_in(cur_byte), .crc_out(crc_next));

    rxaf_decide #(
        .ADDR_BYTES(ADDR_BYTES), .MASK_BITS(MASK_BITS), .LEN_W(LEN_W),
        .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)
    ) u_decide (
        .dst(ctl_q.dst), .station(ctl_q.station), .crc(ctl_q.crc), .mask(hash_mask),
        .en(ctl_q.en), .crc_err(ctl_q.crc_err), .len(ctl_q.len),
        .accept(dec_accept), .status(dec_status)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctl_d.st      = ST_HASH;
                    ctl_d.cnt     = '0;
                    ctl_d.dst     = dst_addr;
                    ctl_d.station = station_addr;
                    ctl_d.len     = frame_len;
                    ctl_d.crc_err = crc_err;
                    ctl_d.en      = '{ia: en_ia, bcast: en_bcast, mcast: en_mcast,
                                      hash: en_hash, prom: en_prom};
                    ctl_d.crc     = '1;
                end
            end
            ST_HASH: begin
                ctl_d.crc = crc_next;
                if (ctl_q.cnt == CNT_W'(ADDR_BYTES - 1)) ctl_d.st  = ST_DECIDE;
                else                                    ctl_d.cnt = ctl_q.cnt + 1'b1;
            end
            ST_DECIDE: begin
                ctl_d.done   = 1'b1;
                ctl_d.accept = dec_accept;
                ctl_d.status = dec_status;
                ctl_d.st     = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign done   = ctl_q.done;
    assign accept = ctl_q.accept;
    assign status = ctl_q.status;
endmodule

// File: rtl/rx_addr_filter_chk.sv
module rx_addr_filter_chk #(
    parameter int LAT       = 7,
    parameter int SEL_W     = 3,
    parameter int MASK_BITS = 64
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic                 done,
    input logic                 accept,
    input logic [15:0]          status,
    input logic                 mask_wr,
    input logic [SEL_W-1:0]     mask_sel,
    input logic [7:0]           mask_byte,
    input logic [MASK_BITS-1:0] mask
);
    logic       pend;
    logic [7:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= 1'b0;
            cnt  <= '0;
        end else if (done) begin
            pend <= start;
            cnt  <= '0;
        end else if (pend) begin
            cnt <= cnt + 8'd1;
        end else if (start) begin
            pend <= 1'b1;
            cnt  <= '0;
        end
    end

    assert_done_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pend && cnt == 8'(LAT)));

    assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_result_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(accept) && $stable(status)));

    assert_no_spurious_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pend |-> !done);

    assert_reject_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !accept) |-> (status == 16'h0004));

    assert_accept_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && accept) |-> (status[8] && status[2]));

    assert_mask_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> (mask[$past(mask_sel)*8 +: 8] == $past(mask_byte)));
endmodule

bind rx_addr_filter rx_addr_filter_chk #(
    .LAT(ADDR_BYTES + 1), .SEL_W(SEL_W), .MASK_BITS(MASK_BITS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .accept(accept),
    .status(status), .mask_wr(mask_wr), .mask_sel(mask_sel),
    .mask_byte(mask_byte), .mask(hash_mask)
);

// File: tb/rx_addr_filter_tb.sv
module rx_addr_filter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [47:0] dst_addr = '0;
    logic [15:0] frame_len = '0;
    logic        crc_err = 1'b0;
    logic [47:0] station_addr = 48'h665544332211;
    logic        en_ia = 0, en_bcast = 0, en_mcast = 0, en_hash = 0, en_prom = 0;
    logic        mask_wr = 1'b0;
    logic [2:0]  mask_sel = '0;
    logic [7:0]  mask_byte = '0;
    logic        done, accept;
    logic [15:0] status;

    rx_addr_filter u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dst_addr(dst_addr),
        .frame_len(frame_len), .crc_err(crc_err), .station_addr(station_addr),
        .en_ia(en_ia), .en_bcast(en_bcast), .en_mcast(en_mcast), .en_hash(en_hash),
        .en_prom(en_prom), .mask_wr(mask_wr), .mask_sel(mask_sel),
        .mask_byte(mask_byte), .done(done), .accept(accept), .status(status)
    );

    always #5 clk = ~clk;

    integer      cyc = 0;
    integer      checks = 0;
    integer      errors = 0;
    integer      due = -1;
    logic        exp_acc = 1'b0;
    logic [15:0] exp_status = 16'h0000;
    logic        pend_acc = 1'b0;
    logic [15:0] pend_status = 16'h0000;
    logic [63:0] ref_mask = '0;
    string       cur_tag = "R1 reset";
    bit          finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic logic [31:0] ref_crc(input logic [47:0] a);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int b = 0; b < 6; b++)
            for (int i = 0; i < 8; i++)
                c = (c[0] ^ a[b*8+i]) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        return c;
    endfunction

    function automatic int ref_idx(input logic [47:0] a);
        logic [31:0] c = ref_crc(a);
        return int'(c[31:26]);
    endfunction

    // Reference decision built from the requirements
    task automatic model(input logic [47:0] d, input logic [15:0] l, input logic ce);
        int  idx = ref_idx(d);
        bit  hit = ref_mask[idx];
        bit  acc = 0, is_bc = 0, is_mc = 0, is_h = 0;
        int  w = 4;
        if (d == station_addr && (en_ia || en_prom)) acc = 1;
        else if (d == 48'hFFFF_FFFF_FFFF) begin is_bc = 1; acc = en_bcast || en_prom; end
        else if (hit && d[7]) begin is_mc = 1; acc = en_mcast || en_prom; end
        else if (hit) begin is_h = 1; acc = en_hash || en_prom; end
        else acc = en_prom;
        if (acc) begin
            w += 'h100;
            if (is_mc) w += 'h200;
            if (is_h) w += 'h40 + (idx << 9);
            else begin
                if (d == station_addr) w += 'h400;
                if (is_bc) w += 'h800;
                if (ce) w += 'h1000;
                if (l < 64) w += 'h2000;
                if (l > 1518) w += 'h4000;
            end
        end
        pend_acc = acc;
        pend_status = 16'(w);
    endtask

    // Compare every clock, 3 ns after the rising edge
    always @(posedge clk) begin
        #3;
        if (!finished) begin
            if (rst_n && cyc == due) begin
                exp_acc = pend_acc;
                exp_status = pend_status;
            end
            chk({cur_tag, " done"},   {31'd0, done},   {31'd0, (rst_n && cyc == due)});
            chk({cur_tag, " accept"}, {31'd0, accept}, {31'd0, exp_acc});
            chk({cur_tag, " status"}, {16'd0, status}, {16'd0, exp_status});
        end
    end

    task automatic write_mask(input int sel, input logic [7:0] b);
        @(negedge clk);
        mask_wr = 1'b1; mask_sel = 3'(sel); mask_byte = b;
        ref_mask[sel*8 +: 8] = b;
        @(negedge clk);
        mask_wr = 1'b0;
    endtask

    task automatic set_hash_bit(input logic [47:0] a);
        int idx = ref_idx(a);
        write_mask(idx / 8, ref_mask[(idx/8)*8 +: 8] | 8'(1 << (idx % 8)));
    endtask

    task automatic fire(input string tag, input logic [47:0] d, input logic [15:0] l, input logic ce);
        @(negedge clk);
        cur_tag = tag;
        dst_addr = d; frame_len = l; crc_err = ce; start = 1'b1;
        model(d, l, ce);
        due = cyc + 8;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic finish_frame();
        while (cyc <= due) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run(input string tag, input logic [47:0] d, input logic [15:0] l, input logic ce);
        fire(tag, d, l, ce);
        finish_frame();
    endtask

    task automatic enables(input bit ia, input bit bc, input bit mc, input bit h, input bit p);
        en_ia = ia; en_bcast = bc; en_mcast = mc; en_hash = h; en_prom = p;
    endtask

    localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
    localparam logic [47:0] UNI   = 48'h0A0B0C0D0E02;
    localparam logic [47:0] MULTI = 48'h1020304050A3;
    localparam logic [47:0] OTHER = 48'h123456789A04;

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3: station match accepted; then falls through and is rejected (R10)
        enables(1, 0, 0, 0, 0);
        run("R3 ia accept", station_addr, 16'd100, 1'b0);
        enables(0, 0, 0, 0, 0);
        run("R3 ia fallthrough R10", station_addr, 16'd100, 1'b0);

        // R4: broadcast, and no hash route for it
        enables(0, 1, 0, 0, 0);
        run("R4 bcast accept", BCAST, 16'd100, 1'b0);
        set_hash_bit(BCAST);
        enables(0, 0, 1, 1, 0);
        run("R4 bcast no hash", BCAST, 16'd100, 1'b0);

        // R5 R7: hashed unicast carries the index
        set_hash_bit(UNI);
        enables(0, 0, 0, 1, 0);
        run("R5 R7 hashed unicast", UNI, 16'd200, 1'b0);
        enables(0, 0, 1, 0, 0);
        run("R7 hashed unicast disabled", UNI, 16'd200, 1'b0);

        // R6: multicast through the hash table
        set_hash_bit(MULTI);
        enables(0, 0, 1, 0, 0);
        run("R6 multicast accept", MULTI, 16'd30, 1'b1);
        enables(0, 0, 0, 1, 0);
        run("R6 multicast not hash", MULTI, 16'd300, 1'b0);

        // R8: promiscuous only
        enables(0, 0, 0, 0, 1);
        run("R8 prom accept", OTHER, 16'd64, 1'b0);
        enables(1, 1, 1, 1, 0);
        run("R8 no prom", OTHER, 16'd64, 1'b0);

        // R9: address-type format flags
        enables(1, 0, 0, 0, 0);
        run("R9 runt crcerr", station_addr, 16'd40, 1'b1);
        run("R9 oversize", station_addr, 16'd2000, 1'b0);
        run("R9 max edge", station_addr, 16'd1518, 1'b0);

        // R11: clearing the byte drops the hit; other byte intact
        write_mask(ref_idx(UNI) / 8, 8'h00);
        enables(0, 0, 0, 1, 0);
        run("R11 mask byte cleared", UNI, 16'd200, 1'b0);
        enables(0, 0, 1, 0, 0);
        run("R11 other byte intact", MULTI, 16'd200, 1'b0);

        // R2: start while busy is ignored
        enables(1, 0, 0, 0, 0);
        fire("R2 busy start", station_addr, 16'd100, 1'b0);
        @(negedge clk);
        dst_addr = BCAST; en_ia = 0; en_prom = 1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        finish_frame();
        repeat (10) @(negedge clk);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL R1 watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule